// File: doc/BRIEF.md
# Pin Bank with Per-Pin Trigger Detection

This block is one bank of general-purpose pins, between 6 and 16 of them, set by a parameter. Software controls it through a 32-bit word-addressed bus. Each pin has three parts:

- a direction bit that drives the pad's output enable;
- an output latch that feeds the pad's data line;
- an input path that is synchronized before software or the trigger logic sees it.

Every pin has its own trigger detector. It can be set to fire on a falling edge, a rising edge, either edge, a low level or a high level. When a pin's interrupt is enabled and its trigger condition is met, a sticky status bit is set. A write-one-to-clear slot removes status bits. Separate mask-set and mask-clear slots hide pins from the single interrupt request line without disturbing their status. A separate readback slot shows the masked status, which is exactly what drives the request line.

The bank sits behind a host bus bridge. The bridge presents a word index, a write strobe and write data, and it takes read data combinationally in the same cycle. A soft-reset input forces every register back to its default for as long as it is held high. Driving it high and then low therefore restores the bank to its reset state.

Top module: `pinbank_irq`

## Requirements
- R1: After the asynchronous reset every readable slot returns zero, `pin_oe` and `pin_out` are all zero and `irq_out` is low.
- R2: Word index selects the register: 0 enable, 1 status, 2 masked status, 3 status clear, 4 mask set (reads back the mask), 5 mask clear (reads zero), 6 output latch, 7 input levels, 8 direction, 9 trigger modes of pins 0-7, 10 trigger modes of pins 8-15, 11 reserved (reads zero, writes ignored). Indexes 12-15 read zero.
- R3: A direction bit of 1 asserts that pin's `pin_oe`. `pin_out` always presents the output latch.
- R4: The input-level slot returns `pin_in` through a two-flop synchronizer, so a change is readable from the second rising edge after it. Writes to this slot have no effect.
- R5: A trigger mode is 3 bits: 000 falling, 001 rising, 010 low level, 011 high level, 100 either edge. Codes 101-111 never trigger. Pin p uses bits [4p+2:4p] of slot 9 for p<8, and bits [4(p-8)+2:4(p-8)] of slot 10 otherwise. The fourth bit of each nibble reads zero.
- R6: In the three edge modes, a status bit is set when the synchronized level differs in the named direction from its value one cycle earlier. The status is readable no later than four clock edges after the pin change.
- R7: In the two level modes the status bit is set on every cycle that the level holds. A clear issued while the level persists is overridden in the same cycle, so the bit reads 1 again.
- R8: A status bit can become set only when its enable bit was 1 in the previous cycle. Once set, it stays set until cleared or reset.
- R9: Writing 1 to a bit of the clear slot clears that status bit. Bits written as 0 leave status unchanged.
- R10: Writing 1 to a bit of the mask-set slot masks the pin, and writing 1 to the mask-clear slot unmasks it. Zeros written to either slot change nothing.
- R11: The masked-status slot reads status AND NOT mask, and `irq_out` is the OR of that vector.
- R12: While `soft_rst` is high, enable, status, mask, output latch, direction, modes and synchronizers are forced to zero. They stay zero after it falls until software writes them.
- R13: Bits at or above the implemented pin count read zero in every per-pin slot and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously by the caller |
| soft_rst | input | 1 | Synchronous register clear while high |
| bus_wr | input | 1 | Write strobe for the addressed slot |
| bus_addr | input | 4 | Word index of the register slot |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed slot, combinational |
| pin_in | input | NPINS | Pad input levels, asynchronous |
| pin_out | output | NPINS | Output latch towards the pads |
| pin_oe | output | NPINS | Per-pin output enable (direction) |
| irq_out | output | 1 | Interrupt request, OR of unmasked status |

## Verification
The bench first sets each pin to a start level and lets the detector settle. It then moves the pin to an end level and reads status. Pin, mode, start level, end level and enable are all chosen at random.

- Stable pins separate the edge modes from the level modes.
- Same-level pairs show that edges need a real transition.
- Opposite pairs separate rising from falling from either-edge.

Directed cases cover several behaviours:

- A sticky edge status survives idle cycles and zero-valued clears.
- A level status comes back immediately after it is cleared.
- Masking toggles `irq_out` and the masked-status slot while raw status is unchanged.
- Out-of-range bits and mode-nibble padding read zero on a 12-pin instance.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  localparam int DW          = 32;
  localparam int SLOTS       = 12;
  localparam int AW          = $clog2(SLOTS);
  localparam int MODE_W      = 3;
  localparam int MODE_STRIDE = 4;
  localparam int FIELDS_PER  = DW / MODE_STRIDE;
  localparam int MAX_PINS    = 2 * FIELDS_PER;
  localparam int MIN_PINS    = 6;

  // Word index of each register slot; software decodes this order.
  typedef enum logic [AW-1:0] {
    SL_IEN   = 4'd0,
    SL_STAT  = 4'd1,
    SL_DISP  = 4'd2,
    SL_ICLR  = 4'd3,
    SL_MSET  = 4'd4,
    SL_MCLR  = 4'd5,
    SL_DOUT  = 4'd6,
    SL_DIN   = 4'd7,
    SL_DIR   = 4'd8,
    SL_MODE0 = 4'd9,
    SL_MODE1 = 4'd10,
    SL_RSVD  = 4'd11
  } slot_e;

  // Per-pin trigger selection.
  typedef enum logic [MODE_W-1:0] {
    TRG_FALL = 3'b000,
    TRG_RISE = 3'b001,
    TRG_LOW  = 3'b010,
    TRG_HIGH = 3'b011,
    TRG_BOTH = 3'b100
  } trig_e;

endpackage

// File: rtl/pinbank_sync.sv
// Multi-stage synchronizer plus one history stage for edge detection.
module pinbank_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);

  localparam int DEPTH = STAGES + 1;

  logic [W-1:0] stg_q [DEPTH];
  logic [W-1:0] stg_d [DEPTH];

  always_comb begin
    stg_d[0] = clr ? '0 : d;
    for (int k = 1; k < DEPTH; k++) begin
      stg_d[k] = clr ? '0 : stg_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stg_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) stg_q[k] <= stg_d[k];
    end
  end

  assign q      = stg_q[STAGES-1];
  assign q_prev = stg_q[STAGES];

endmodule

// File: rtl/pinbank_trig.sv
// Combinational trigger condition for one pin.
module pinbank_trig
  import pinbank_pkg::*;
(
  input  logic              lvl,
  input  logic              lvl_prev,
  input  logic [MODE_W-1:0] mode,
  output logic              hit
);

  always_comb begin
    case (mode)
      TRG_FALL: hit = lvl_prev & ~lvl;
      TRG_RISE: hit = lvl & ~lvl_prev;
      TRG_LOW:  hit = ~lvl;
      TRG_HIGH: hit = lvl;
      TRG_BOTH: hit = lvl ^ lvl_prev;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
  import pinbank_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_out
);

  generate
    if (NPINS < MIN_PINS || NPINS > MAX_PINS) begin : g_bad_count
      $error("pinbank_irq: NPINS out of range");
    end
  endgenerate

  // ---------------- write decode ----------------
  logic we_ien, we_iclr, we_mset, we_mclr, we_dout, we_dir, we_mode0, we_mode1;
  logic [NPINS-1:0] wbits;

  always_comb begin
    we_ien   = bus_wr && (bus_addr == SL_IEN);
    we_iclr  = bus_wr && (bus_addr == SL_ICLR);
    we_mset  = bus_wr && (bus_addr == SL_MSET);
    we_mclr  = bus_wr && (bus_addr == SL_MCLR);
    we_dout  = bus_wr && (bus_addr == SL_DOUT);
    we_dir   = bus_wr && (bus_addr == SL_DIR);
    we_mode0 = bus_wr && (bus_addr == SL_MODE0);
    we_mode1 = bus_wr && (bus_addr == SL_MODE1);
    wbits    = bus_wdata[NPINS-1:0];
  end

  // ---------------- input path ----------------
  logic [NPINS-1:0] lvl_s, lvl_p, hit_v;

  pinbank_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (soft_rst),
    .d      (pin_in),
    .q      (lvl_s),
    .q_prev (lvl_p)
  );

  // ---------------- state ----------------
  logic [NPINS-1:0]  ien_q, ien_d;
  logic [NPINS-1:0]  stat_q, stat_d;
  logic [NPINS-1:0]  mask_q, mask_d;
  logic [NPINS-1:0]  dout_q, dout_d;
  logic [NPINS-1:0]  dir_q, dir_d;
  logic [MODE_W-1:0] mode_q [NPINS];
  logic [MODE_W-1:0] mode_d [NPINS];

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_pin
      localparam int SEL = (g < FIELDS_PER) ? 0 : 1;
      localparam int LSB = MODE_STRIDE * (g % FIELDS_PER);

      pinbank_trig u_trig (
        .lvl      (lvl_s[g]),
        .lvl_prev (lvl_p[g]),
        .mode     (mode_q[g]),
        .hit      (hit_v[g])
      );

      always_comb begin
        mode_d[g] = mode_q[g];
        if (soft_rst) begin
          mode_d[g] = '0;
        end else if ((SEL == 0 && we_mode0) || (SEL == 1 && we_mode1)) begin
          mode_d[g] = bus_wdata[LSB +: MODE_W];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q[g] <= '0;
        else        mode_q[g] <= mode_d[g];
      end
    end
  endgenerate

  // Next-state for the per-pin vectors.
  always_comb begin
    ien_d  = ien_q;
    mask_d = mask_q;
    dout_d = dout_q;
    dir_d  = dir_q;
    stat_d = stat_q;
    if (soft_rst) begin
      ien_d  = '0;
      mask_d = '0;
      dout_d = '0;
      dir_d  = '0;
      stat_d = '0;
    end else begin
      if (we_ien)  ien_d  = wbits;
      if (we_dout) dout_d = wbits;
      if (we_dir)  dir_d  = wbits;
      if (we_mset) mask_d = mask_q | wbits;
      if (we_mclr) mask_d = mask_q & ~wbits;
      // Clear first, then new detections win in the same cycle.
      stat_d = (stat_q & ~(we_iclr ? wbits : '0)) | (hit_v & ien_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= '0;
      stat_q <= '0;
      mask_q <= '0;
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      ien_q  <= ien_d;
      stat_q <= stat_d;
      mask_q <= mask_d;
      dout_q <= dout_d;
      dir_q  <= dir_d;
    end
  end

  // ---------------- outputs and readback ----------------
  logic [NPINS-1:0]  pend;
  logic [2*DW-1:0]   mode_flat;

  always_comb begin
    mode_flat = '0;
    for (int p = 0; p < NPINS; p++) begin
      mode_flat[MODE_STRIDE*p +: MODE_W] = mode_q[p];
    end
  end

  assign pend    = stat_q & ~mask_q;
  assign irq_out = |pend;
  assign pin_out = dout_q;
  assign pin_oe  = dir_q;

  always_comb begin
    case (bus_addr)
      SL_IEN:   bus_rdata = DW'(ien_q);
      SL_STAT:  bus_rdata = DW'(stat_q);
      SL_DISP:  bus_rdata = DW'(pend);
      SL_MSET:  bus_rdata = DW'(mask_q);
      SL_DOUT:  bus_rdata = DW'(dout_q);
      SL_DIN:   bus_rdata = DW'(lvl_s);
      SL_DIR:   bus_rdata = DW'(dir_q);
      SL_MODE0: bus_rdata = mode_flat[DW-1:0];
      SL_MODE1: bus_rdata = mode_flat[2*DW-1:DW];
      default:  bus_rdata = '0;
    endcase
  end

  // ---------------- assertions ----------------
  // R8
  stat_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(ien_q)) == '0));

  // R9
  iclr_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_iclr && !soft_rst) |=>
      ((stat_q & $past(wbits) & ~$past(hit_v & ien_q)) == '0));

  // R10
  mset_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_mset && !soft_rst) |=> ((mask_q & $past(wbits)) == $past(wbits)));

  // R10
  mclr_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_mclr && !soft_rst) |=> ((mask_q & $past(wbits)) == '0));

  // R12
  soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ien_q == '0 && stat_q == '0 && mask_q == '0 && pin_oe == '0));

  // R8
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_iclr && !soft_rst) |=> (($past(stat_q) & ~stat_q) == '0));

endmodule

// File: tb/sim_pinbank_irq.sv
module sim_pinbank_irq;
  import pinbank_pkg::*;

  localparam int NP = 12;

  logic          clk, rst_n, soft_rst, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic [NP-1:0] pin_in, pin_out, pin_oe;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pinbank_irq #(.NPINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = AW'(a);
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Expected status of one enabled pin after the level moves from a to b.
  function automatic bit trig_expect(input int m, input bit a, input bit b);
    case (m)
      0: return a && !b;
      1: return !a && b;
      2: return !a || !b;
      3: return a || b;
      4: return a != b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] mode_word(input int m);
    logic [31:0] w = '0;
    for (int f = 0; f < 8; f++) w[4*f +: 3] = 3'(m);
    return w;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [NP-1:0] full;
    void'($urandom(32'd20240611));
    full = '1;
    rst_n = 1'b0; soft_rst = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1: reset state
    for (int a = 0; a < 16; a++) begin
      rd(a, r);
      check($sformatf("R1 slot %0d after reset", a), r, 32'h0);
    end
    check("R1 pin_oe after reset", 32'(pin_oe), 32'h0);
    check("R1 pin_out after reset", 32'(pin_out), 32'h0);
    check("R1 irq after reset", 32'(irq_out), 32'h0);

    // R3, R13: direction and output latch
    wr(8, 32'h0000_0A5A);
    wr(6, 32'h0000_03C3);
    check("R3 pin_oe follows direction", 32'(pin_oe), 32'h0A5A);
    check("R3 pin_out follows latch", 32'(pin_out), 32'h03C3);
    wr(8, 32'hFFFF_FFFF);
    rd(8, r);
    check("R13 direction upper bits", r, 32'(full));
    wr(6, 32'hFFFF_0000);
    rd(6, r);
    check("R13 latch upper bits", r, 32'h0000_0000);
    rd(11, r);
    check("R2 reserved slot reads zero", r, 32'h0);

    // R4: input synchronizer and read-only slot
    @(negedge clk);
    pin_in = 12'h5A5;
    @(posedge clk); @(posedge clk); #1;
    bus_addr = AW'(7); #0.5;
    check("R4 input level after two edges", bus_rdata, 32'h5A5);
    wr(7, 32'h0000_0000);
    rd(7, r);
    check("R4 write to input slot ignored", r, 32'h5A5);
    pin_in = '0;
    idle(4);

    // R5: mode packing and padding bits
    wr(9, 32'hFFFF_FFFF);
    wr(10, 32'hFFFF_FFFF);
    rd(9, r);
    check("R5 mode slot 0 padding", r, 32'h7777_7777);
    rd(10, r);
    check("R5 mode slot 1 padding and R13", r, 32'h0000_7777);
    wr(9, 32'h4321_0432);
    rd(9, r);
    check("R5 mode slot 0 readback", r, 32'h4321_0432);

    // R6, R7, R8: random trigger patterns
    for (int it = 0; it < 80; it++) begin
      int p, m;
      bit a, b, en;
      p  = $urandom_range(0, NP - 1);
      m  = $urandom_range(0, 4);
      a  = 1'($urandom_range(0, 1));
      b  = 1'($urandom_range(0, 1));
      en = ($urandom_range(0, 3) != 0);
      wr(0, 32'h0);
      @(negedge clk);
      pin_in = '0;
      pin_in[p] = a;
      idle(4);
      wr(9, mode_word(m));
      wr(10, mode_word(m));
      wr(3, 32'hFFFF_FFFF);
      wr(0, en ? (32'h1 << p) : 32'h0);
      wr(3, 32'h1 << p);
      @(negedge clk);
      pin_in[p] = b;
      idle(4);
      rd(1, r);
      check($sformatf("R6 R7 R8 pin %0d mode %0d %0d->%0d en %0d", p, m, a, b, en),
            r, (en && trig_expect(m, a, b)) ? (32'h1 << p) : 32'h0);
    end
    wr(0, 32'h0);
    wr(3, 32'hFFFF_FFFF);
    @(negedge clk);
    pin_in = '0;
    idle(4);

    // R8, R9: sticky edge status and clear semantics
    wr(9, mode_word(1));
    wr(10, mode_word(1));
    wr(0, 32'h0000_0008);
    @(negedge clk);
    pin_in[3] = 1'b1;
    idle(4);
    @(negedge clk);
    pin_in[3] = 1'b0;
    idle(6);
    rd(1, r);
    check("R8 edge status sticky", r, 32'h8);
    wr(3, 32'h0000_0000);
    rd(1, r);
    check("R9 zero clear has no effect", r, 32'h8);

    // R10, R11: masking
    check("R11 irq with unmasked status", 32'(irq_out), 32'h1);
    wr(4, 32'h0000_0008);
    rd(4, r);
    check("R10 mask set readback", r, 32'h8);
    check("R11 irq masked", 32'(irq_out), 32'h0);
    rd(2, r);
    check("R11 masked status slot", r, 32'h0);
    rd(1, r);
    check("R10 raw status kept under mask", r, 32'h8);
    wr(4, 32'h0);
    wr(5, 32'h0);
    rd(4, r);
    check("R10 zero writes keep mask", r, 32'h8);
    wr(5, 32'h0000_0008);
    rd(5, r);
    check("R2 mask clear slot reads zero", r, 32'h0);
    rd(2, r);
    check("R11 masked status after unmask", r, 32'h8);
    check("R11 irq after unmask", 32'(irq_out), 32'h1);
    wr(3, 32'h0000_0008);
    rd(1, r);
    check("R9 one clears status", r, 32'h0);
    check("R11 irq after clear", 32'(irq_out), 32'h0);

    // R7: level status returns right after clear
    wr(9, mode_word(3));
    wr(0, 32'h0000_0004);
    @(negedge clk);
    pin_in[2] = 1'b1;
    idle(4);
    wr(3, 32'h0000_0004);
    rd(1, r);
    check("R7 level status re-set after clear", r, 32'h4);

    // R12: soft reset
    wr(4, 32'h0000_0FFF);
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    pin_in = '0;
    idle(1);
    rd(0, r);
    check("R12 enable cleared", r, 32'h0);
    rd(1, r);
    check("R12 status cleared", r, 32'h0);
    rd(4, r);
    check("R12 mask cleared", r, 32'h0);
    rd(9, r);
    check("R12 modes cleared", r, 32'h0);
    check("R12 pin_oe cleared", 32'(pin_oe), 32'h0);
    check("R12 irq low", 32'(irq_out), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule